// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block sits on the controller side of an SDRAM channel and owns the command pins from reset until the memory is ready for normal traffic. It first holds the bus quiet for a stabilisation period. During that time it drives NOP with clock enable and the data mask high. It then precharges every bank and issues a configurable number of auto-refresh commands, each spaced by the row-cycle time. Last, it programs the mode register from the configured CAS latency, burst length and burst type.

All waits are cycle counts given as parameters, and one shared down-counter is loaded from them. The configuration is captured and checked in the last cycle of the stabilisation wait. If it holds a reserved code, the sequencer parks in an error state. That state drives NOP forever and never raises the done flag. Every wait parameter must be at least 2.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset and for STABLE_CYCLES cycles after reset is released, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111), cke is 1, every dqm bit is 1, addr and ba are 0, and init_done is 0.
- R2: In the cycle after the stabilisation wait ends, a precharge-all is driven: command 0010, addr bit 10 high and every other addr bit 0, ba 0.
- R3: The first auto-refresh comes exactly TRP_CYCLES cycles after the precharge, with NOP on every cycle in between.
- R4: Exactly NUM_REFRESH auto-refresh commands (0001, addr 0, ba 0) are issued, each TRC_CYCLES cycles after the previous one, with NOP in between.
- R5: The mode register set (0000) comes TRC_CYCLES cycles after the last refresh. Its addr carries the burst length in bits 2..0, the burst type in bit 3 (0 sequential, 1 interleaved) and the CAS latency in bits 6..4. All higher addr bits and ba are 0.
- R6: TRSC_CYCLES cycles after the mode register set, init_done rises and the dqm bits fall to 0. Both then stay at those values, and the command stays NOP, until reset.
- R7: Only CAS latency codes 010 and 011 are valid. Any other code sends the block to an error state: NOP forever, no precharge, init_done 0, dqm high.
- R8: Burst length codes 000, 001, 010 and 011 are valid with either burst type. Code 111 (full page) is valid only with sequential type. Every other combination gives the same error behaviour as R7.
- R9: The configuration is sampled only in the last stabilisation cycle. Changes after that point do not alter the mode word that is written.
- R10: Asserting the synchronous reset at any point restarts the whole sequence from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_burst_type | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins |
| ba | output | BANK_W | Bank select pins |
| cke | output | 1 | Clock enable |
| dqm | output | DQM_W | Data mask, high during initialization |
| init_done | output | 1 | High once the device is ready |

## Verification
The bench builds the block with STABLE_CYCLES=16, TRP_CYCLES=3, TRC_CYCLES=5, TRSC_CYCLES=2 and NUM_REFRESH=8. A complete sequence then takes 61 cycles, so every configuration in the table can be followed cycle by cycle to completion. Because the precharge gap and the refresh gap differ, a swapped or off-by-one wait moves a command onto a cycle where the bench expects NOP. Eight refreshes is the smallest legal count, so one refresh too many or too few shifts the mode register set.

// File: rtl/sdram_init_pkg.sv
// Shared encodings for the SDRAM initialization sequencer.
// Assumes command pins are packed as {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        ST_STABLE,
        ST_PRECHG,
        ST_PRE_GAP,
        ST_REFRESH,
        ST_REF_GAP,
        ST_MODESET,
        ST_MODE_GAP,
        ST_READY,
        ST_FAULT
    } init_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_wait_timer.sv
// Shared down-counter for every wait of the init sequence.
// It comes out of reset holding RST_VAL. A load overrides the count.
// It otherwise counts down to zero and holds there.
// Assumes load values fit in CNT_W bits.
module sdram_wait_timer #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count;

    // Load, count down, or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= CNT_W'(RST_VAL);
        else if (load)           count <= load_val;
        else if (count != '0)    count <= count - 1'b1;
    end

    assign expired = (count == '0);

    // A running count that is not reloaded steps down by exactly one (R1, R3, R4, R6).
    assert_timer_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count != '0) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/sdram_mode_word.sv
// Packs the configuration into the mode register word and validates it.
// Latency sits in bits 6..4, type in bit 3, length in bits 2..0.
// Reserved latency or length codes clear cfg_ok. Purely combinational.
module sdram_mode_word #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [2:0]        cas_lat,
    input  logic [2:0]        burst_len,
    input  logic              burst_type,
    output logic [ADDR_W-1:0] word,
    output logic              cfg_ok
);
    logic lat_ok;
    logic len_ok;

    // Latency: only two and three cycles are defined.
    always_comb lat_ok = (cas_lat == 3'd2) || (cas_lat == 3'd3);

    // Length: 1/2/4/8 always; full page only for sequential bursts.
    always_comb len_ok = (burst_len[2] == 1'b0) ||
                         (burst_len == 3'b111 && burst_type == 1'b0);

    // Assemble the word with upper bits cleared.
    always_comb begin
        word      = '0;
        word[2:0] = burst_len;
        word[3]   = burst_type;
        word[6:4] = cas_lat;
    end

    assign cfg_ok = lat_ok && len_ok;

endmodule

// File: rtl/sdram_init_seq.sv
// Power-on initialization sequencer for an SDRAM channel.
// After reset it waits STABLE_CYCLES with NOP, issues a precharge-all and
// waits TRP_CYCLES. It then issues NUM_REFRESH refreshes TRC_CYCLES apart,
// writes the mode register and waits TRSC_CYCLES before raising init_done.
// Assumes: every *_CYCLES >= 2, ADDR_W >= 11, and the configuration is
// stable in the last stabilisation cycle, when it is captured.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BANK_W        = 2,
    parameter int unsigned DQM_W         = 2,
    parameter int unsigned STABLE_CYCLES = 20000,
    parameter int unsigned TRP_CYCLES    = 3,
    parameter int unsigned TRC_CYCLES    = 7,
    parameter int unsigned TRSC_CYCLES   = 2,
    parameter int unsigned NUM_REFRESH   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic              init_done
);
    localparam int unsigned MAX_WAIT = max2(max2(STABLE_CYCLES, TRP_CYCLES),
                                            max2(TRC_CYCLES, TRSC_CYCLES));
    localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int unsigned REF_W    = $clog2(NUM_REFRESH + 1);
    localparam int unsigned ALL_BANK_BIT = 10;
    localparam logic [CNT_W-1:0] LD_TRP  = CNT_W'(TRP_CYCLES - 2);
    localparam logic [CNT_W-1:0] LD_TRC  = CNT_W'(TRC_CYCLES - 2);
    localparam logic [CNT_W-1:0] LD_TRSC = CNT_W'(TRSC_CYCLES - 2);

    init_state_e       state, state_nx;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [REF_W-1:0]  ref_cnt;
    logic [ADDR_W-1:0] mode_raw;
    logic [ADDR_W-1:0] mode_q;
    logic              cfg_ok;
    logic [3:0]        cmd;

    sdram_wait_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (STABLE_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_mode_word #(
        .ADDR_W (ADDR_W)
    ) u_mode (
        .cas_lat    (cfg_cas_lat),
        .burst_len  (cfg_burst_len),
        .burst_type (cfg_burst_type),
        .word       (mode_raw),
        .cfg_ok     (cfg_ok)
    );

    // Next state and timer reload for each step of the sequence.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_STABLE:   if (tmr_expired) state_nx = cfg_ok ? ST_PRECHG : ST_FAULT;
            ST_PRECHG:   begin state_nx = ST_PRE_GAP; tmr_load = 1'b1; tmr_val = LD_TRP; end
            ST_PRE_GAP:  if (tmr_expired) state_nx = ST_REFRESH;
            ST_REFRESH:  begin state_nx = ST_REF_GAP; tmr_load = 1'b1; tmr_val = LD_TRC; end
            ST_REF_GAP:  if (tmr_expired)
                             state_nx = (ref_cnt == REF_W'(NUM_REFRESH)) ? ST_MODESET : ST_REFRESH;
            ST_MODESET:  begin state_nx = ST_MODE_GAP; tmr_load = 1'b1; tmr_val = LD_TRSC; end
            ST_MODE_GAP: if (tmr_expired) state_nx = ST_READY;
            ST_READY:    state_nx = ST_READY;
            ST_FAULT:    state_nx = ST_FAULT;
            default:     state_nx = ST_FAULT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STABLE;
        else        state <= state_nx;
    end

    // Count refreshes issued since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ref_cnt <= '0;
        else if (state == ST_REFRESH) ref_cnt <= ref_cnt + 1'b1;
    end

    // Capture the mode word in the last stabilisation cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  mode_q <= '0;
        else if (state == ST_STABLE && tmr_expired)  mode_q <= mode_raw;
    end

    // Drive command, address and bank pins from the current state.
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        unique case (state)
            ST_PRECHG:  begin cmd = CMD_PRE; addr[ALL_BANK_BIT] = 1'b1; end
            ST_REFRESH: cmd = CMD_REF;
            ST_MODESET: begin cmd = CMD_MRS; addr = mode_q; end
            default:    cmd = CMD_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign cke       = 1'b1;
    assign init_done = (state == ST_READY);
    assign dqm       = {DQM_W{~init_done}};

    // A precharge is always followed by a NOP gap (R3).
    assert_pre_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |=> (cmd == CMD_NOP));

    // A refresh is always followed by a NOP gap (R4).
    assert_ref_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |=> (cmd == CMD_NOP));

    // The refresh count never exceeds the configured number (R4).
    assert_ref_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt <= REF_W'(NUM_REFRESH));

    // A written mode word always carries a valid latency code (R7).
    assert_mrs_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> (addr[6:4] == 3'd2 || addr[6:4] == 3'd3));

    // Ready is sticky, with NOP and the mask released (R6).
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && cmd == CMD_NOP && dqm == '0));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
    localparam int S    = 16;
    localparam int TRP  = 3;
    localparam int TRC  = 5;
    localparam int TRSC = 2;
    localparam int NREF = 8;
    localparam int AW   = 12;
    localparam int T_MRS  = S + TRP + NREF * TRC;
    localparam int T_DONE = T_MRS + TRSC;
    localparam int RUN_LEN = T_DONE + 6;

    // Each entry: {cas_lat[2:0], burst_type, burst_len[2:0], valid}.
    localparam int NVEC = 8;
    localparam logic [7:0] VECS [NVEC] = '{
        {3'd2, 1'b0, 3'b011, 1'b1},
        {3'd3, 1'b1, 3'b000, 1'b1},
        {3'd2, 1'b1, 3'b010, 1'b1},
        {3'd3, 1'b0, 3'b111, 1'b1},
        {3'd3, 1'b1, 3'b111, 1'b0},
        {3'd1, 1'b0, 3'b001, 1'b0},
        {3'd4, 1'b0, 3'b010, 1'b0},
        {3'd2, 1'b0, 3'b101, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_cas_lat = 3'd2;
    logic [2:0]    cfg_burst_len = 3'd0;
    logic          cfg_burst_type = 1'b0;
    logic          cs_n, ras_n, cas_n, we_n, cke, init_done;
    logic [AW-1:0] addr;
    logic [1:0]    ba;
    logic [1:0]    dqm;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .ADDR_W(AW), .BANK_W(2), .DQM_W(2),
        .STABLE_CYCLES(S), .TRP_CYCLES(TRP), .TRC_CYCLES(TRC),
        .TRSC_CYCLES(TRSC), .NUM_REFRESH(NREF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_cas_lat(cfg_cas_lat), .cfg_burst_len(cfg_burst_len),
        .cfg_burst_type(cfg_burst_type),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .cke(cke), .dqm(dqm), .init_done(init_done)
    );

    // Packed observation: {cmd[3:0], addr[11:0], ba[1:0], cke, dqm[1:0], done}.
    function automatic logic [21:0] observe();
        return {cs_n, ras_n, cas_n, we_n, addr, ba, cke, dqm, init_done};
    endfunction

    function automatic logic [21:0] expect_at(int t, bit ok, logic [2:0] cl,
                                              logic bt, logic [2:0] bl);
        logic [3:0]    c = 4'b0111;
        logic [AW-1:0] a = '0;
        bit            d = 0;
        int            r = t - S - TRP;
        if (ok && t >= S) begin
            if (t == S) begin c = 4'b0010; a[10] = 1'b1; end
            else if (r >= 0 && r < NREF * TRC && (r % TRC) == 0) c = 4'b0001;
            else if (t == T_MRS) begin c = 4'b0000; a[6:0] = {cl, bt, bl}; end
            d = (t >= T_DONE);
        end
        return {c, a, 2'b00, 1'b1, d ? 2'b00 : 2'b11, d};
    endfunction

    function automatic string phase_tag(int t, bit ok, logic [2:0] cl);
        if (t < S) return "R1";
        if (!ok) return (cl == 3'd2 || cl == 3'd3) ? "R8" : "R7";
        if (t == S) return "R2";
        if (t < S + TRP) return "R3";
        if (t < T_MRS) return "R4";
        if (t == T_MRS) return "R5";
        return "R6";
    endfunction

    task automatic check(string tag, logic [21:0] act, logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reset, then follow the sequence for n cycles. From cycle swap_at on
    // the configuration is changed to an invalid value (R9).
    task automatic run(logic [2:0] cl, logic bt, logic [2:0] bl, bit ok,
                       int n, int swap_at, string extra);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_cas_lat = cl; cfg_burst_type = bt; cfg_burst_len = bl;
        repeat (2) @(negedge clk);
        check("R1 (in reset)", observe(), expect_at(0, ok, cl, bt, bl));
        rst_n = 1'b1;
        for (int t = 0; t < n; t++) begin
            if (t == swap_at) begin
                cfg_cas_lat = 3'd6; cfg_burst_len = 3'b100; cfg_burst_type = 1'b1;
            end
            check({phase_tag(t, ok, cl), extra}, observe(), expect_at(t, ok, cl, bt, bl));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // Table walk: valid and reserved configurations (R1..R8).
        for (int i = 0; i < NVEC; i++) begin
            run(VECS[i][7:5], VECS[i][4], VECS[i][3:1], VECS[i][0], RUN_LEN, -1, "");
        end
        // R9: configuration turns invalid right after capture; mode word unchanged.
        run(3'd3, 1'b1, 3'b001, 1'b1, RUN_LEN, S, " R9");
        // R10: reset in the middle of the refresh phase, then a full clean run.
        run(3'd2, 1'b0, 3'b010, 1'b1, S + TRP + 2 * TRC + 1, -1, " R10");
        run(3'd2, 1'b0, 3'b001, 1'b1, RUN_LEN, -1, " R10");
        // R6: ready stays put long after completion.
        repeat (20) @(negedge clk);
        check("R6 (hold)", observe(), expect_at(T_DONE + 30, 1, 3'd2, 1'b0, 3'b001));
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule